// File: doc/BRIEF.md
# Second-Level Copy Recovery List

When a value moves out of the first-level register file into a second-level slot, this block keeps a record of the move. Each record holds the first-level register name the value came from and a live window of two branch sequence numbers. The lower bound is the branch that follows the producing instruction. The upper bound is the branch that comes just before the next writer of the same logical register. Readers of the value are dispatched only inside that window. If a branch in the window is mispredicted, the mapping must return to the first level.

On a mispredict the block tests every valid record against the branch's sequence number and captures the set of matches. It then sends out one restore request per cycle. Each request gives the second-level slot and the first-level name to restore. A busy flag stays high until the last request has left. A record is dropped when its owning instruction commits or when its restore request leaves. Sequence numbers wrap, so every window test works modulo the reorder buffer size.

Top module: `l2_copy_recovery`

## Requirements
- R1: After reset, `rst_valid` and `busy` are low and no record is valid.
- R2: A mispredict with sequence number S, taken while idle, selects every valid record whose window satisfies lo ≤ S < hi. Each selected record yields one request that carries its slot index on `rst_slot` and its stored first-level name on `rst_name`.
- R3: Requests leave one per cycle in ascending slot order. The first request appears in the cycle after the mispredict is sampled.
- R4: `busy` is high exactly while requests remain, and `rst_valid` equals `busy`. Each busy cycle removes exactly one pending request.
- R5: A record freed by `free_valid`/`free_slot` before a mispredict produces no request.
- R6: Window tests use arithmetic modulo 2^SEQ_W. A window with lo > hi wraps through zero and covers S ≥ lo or S < hi.
- R7: A mispredict that arrives while `busy` is high is ignored, and the pending set stays unchanged.
- R8: A record becomes invalid when its request leaves, so a repeated mispredict at the same S produces no further request for it.
- R9: A copy into a slot that is already valid replaces the name and the window of that slot.
- R10: A record with lo == hi has an empty window and is never selected.
- R11: When a copy and a free target the same slot in the same cycle, the copy wins and the record is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cp_valid | input | 1 | Copy event |
| cp_slot | input | IDX_W | Second-level slot receiving the value |
| cp_name | input | NAME_W | First-level register name that held the value |
| cp_lo | input | SEQ_W | Sequence number of the branch after the producer |
| cp_hi | input | SEQ_W | Sequence number of the branch before the next writer |
| free_valid | input | 1 | Commit/release event |
| free_slot | input | IDX_W | Slot to release |
| mp_valid | input | 1 | Mispredict event |
| mp_seq | input | SEQ_W | Sequence number of the mispredicted branch |
| rst_valid | output | 1 | Restore request present |
| rst_slot | output | IDX_W | Second-level slot to bring back |
| rst_name | output | NAME_W | First-level name to restore into |
| busy | output | 1 | Restore requests still pending |

## Verification
The hardest state to reach from the ports is a second mispredict that lands while a drain is still running. The bench loads five records with one shared window and mispredicts inside it. It then issues another mispredict straight away, aimed at a different record that must stay untouched. The scoreboard predicts whether a mispredict is taken or dropped from its own count of requests still outstanding. Wrapped windows and windows with lo == hi are reached by choosing the bounds directly at copy time.

// File: rtl/crl_pkg.sv
package crl_pkg;
  // Modular window test: true when lo <= s < hi counting forward from lo,
  // all arithmetic masked to the sequence-number width.
  function automatic logic seq_in_window(input int unsigned lo, input int unsigned hi,
                                         input int unsigned s, input int unsigned mask);
    int unsigned dist_s;
    int unsigned span;
    dist_s = (s - lo) & mask;
    span   = (hi - lo) & mask;
    return dist_s < span;
  endfunction
endpackage

// File: rtl/crl_store.sv
module crl_store #(
  parameter int ENTRIES = 8,
  parameter int NAME_W  = 6,
  parameter int SEQ_W   = 5,
  parameter int IDX_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cp_valid,
  input  logic [IDX_W-1:0]  cp_slot,
  input  logic [NAME_W-1:0] cp_name,
  input  logic [SEQ_W-1:0]  cp_lo,
  input  logic [SEQ_W-1:0]  cp_hi,
  input  logic              free_valid,
  input  logic [IDX_W-1:0]  free_slot,
  input  logic              clr_valid,
  input  logic [IDX_W-1:0]  clr_slot,
  input  logic [SEQ_W-1:0]  probe_seq,
  input  logic [IDX_W-1:0]  rd_slot,
  output logic [ENTRIES-1:0] hit_vec,
  output logic [NAME_W-1:0] rd_name
);
  import crl_pkg::*;

  localparam int unsigned SEQ_MASK = (1 << SEQ_W) - 1;

  logic [ENTRIES-1:0]             ent_valid;
  logic [ENTRIES-1:0][NAME_W-1:0] ent_name;
  logic [ENTRIES-1:0][SEQ_W-1:0]  ent_lo;
  logic [ENTRIES-1:0][SEQ_W-1:0]  ent_hi;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic wr_here;
    logic kill_here;
    assign wr_here   = cp_valid && (cp_slot == IDX_W'(i));
    assign kill_here = (free_valid && (free_slot == IDX_W'(i))) ||
                       (clr_valid && (clr_slot == IDX_W'(i)));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_valid[i] <= 1'b0;
        ent_name[i]  <= '0;
        ent_lo[i]    <= '0;
        ent_hi[i]    <= '0;
      end else if (wr_here) begin
        ent_valid[i] <= 1'b1;
        ent_name[i]  <= cp_name;
        ent_lo[i]    <= cp_lo;
        ent_hi[i]    <= cp_hi;
      end else if (kill_here) begin
        ent_valid[i] <= 1'b0;
      end
    end

    assign hit_vec[i] = ent_valid[i] &&
                        seq_in_window(32'(ent_lo[i]), 32'(ent_hi[i]), 32'(probe_seq), SEQ_MASK);
  end

  assign rd_name = ent_name[rd_slot];

  // R5
  free_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_valid && !(cp_valid && cp_slot == free_slot) |=> !ent_valid[$past(free_slot)]);

  // R8
  restore_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid && !(cp_valid && cp_slot == clr_slot) |=> !ent_valid[$past(clr_slot)]);

  // R11
  copy_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cp_valid |=> ent_valid[$past(cp_slot)]);
endmodule

// File: rtl/crl_pick.sv
module crl_pick #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] req,
  output logic               any,
  output logic [IDX_W-1:0]   idx,
  output logic [ENTRIES-1:0] grant
);
  always_comb begin
    idx   = '0;
    grant = '0;
    for (int k = ENTRIES - 1; k >= 0; k--) begin
      if (req[k]) begin
        idx   = IDX_W'(k);
        grant = ENTRIES'(1) << k;
      end
    end
  end

  assign any = |req;

  // R3
  lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> req[idx] && ((req & ((ENTRIES'(1) << idx) - ENTRIES'(1))) == '0));

  // R3
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (any == (grant != '0)));
endmodule

// File: rtl/l2_copy_recovery.sv
module l2_copy_recovery #(
  parameter int ENTRIES  = 8,
  parameter int L1_REGS  = 64,
  parameter int ROB_SIZE = 32,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int NAME_W  = $clog2(L1_REGS),
  localparam int SEQ_W   = $clog2(ROB_SIZE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cp_valid,
  input  logic [IDX_W-1:0]  cp_slot,
  input  logic [NAME_W-1:0] cp_name,
  input  logic [SEQ_W-1:0]  cp_lo,
  input  logic [SEQ_W-1:0]  cp_hi,
  input  logic              free_valid,
  input  logic [IDX_W-1:0]  free_slot,
  input  logic              mp_valid,
  input  logic [SEQ_W-1:0]  mp_seq,
  output logic              rst_valid,
  output logic [IDX_W-1:0]  rst_slot,
  output logic [NAME_W-1:0] rst_name,
  output logic              busy
);
  logic [ENTRIES-1:0] hit_vec;
  logic [ENTRIES-1:0] pending;
  logic [ENTRIES-1:0] grant;
  logic               pick_any;
  logic [IDX_W-1:0]   pick_idx;
  logic               mp_take;   // mispredict accepted this cycle
  logic               emit;      // one request leaves this cycle

  assign mp_take = mp_valid && !busy;
  assign emit    = pick_any;

  crl_store #(.ENTRIES(ENTRIES), .NAME_W(NAME_W), .SEQ_W(SEQ_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .cp_valid(cp_valid), .cp_slot(cp_slot), .cp_name(cp_name), .cp_lo(cp_lo), .cp_hi(cp_hi),
    .free_valid(free_valid), .free_slot(free_slot),
    .clr_valid(emit), .clr_slot(pick_idx),
    .probe_seq(mp_seq), .rd_slot(pick_idx),
    .hit_vec(hit_vec), .rd_name(rst_name)
  );

  crl_pick #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_pick (
    .clk(clk), .rst_n(rst_n),
    .req(pending), .any(pick_any), .idx(pick_idx), .grant(grant)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       pending <= '0;
    else if (mp_take) pending <= hit_vec;
    else              pending <= pending & ~grant;
  end

  assign busy      = (pending != '0);
  assign rst_valid = pick_any;
  assign rst_slot  = pick_idx;

  // R4
  drain_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $countones(pending) == $countones($past(pending)) - 1);

  // R7
  busy_ignores_mp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && mp_valid |=> pending == ($past(pending) & ~$past(grant)));

  // R3
  emitted_gone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_valid |=> !pending[$past(rst_slot)]);

  // R4
  valid_matches_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_valid == busy);
endmodule

// File: tb/test_l2_copy_recovery.sv
module test_l2_copy_recovery;
  localparam int ENTRIES = 8;
  localparam int IDX_W   = 3;
  localparam int NAME_W  = 6;
  localparam int SEQ_W   = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cp_valid = 1'b0;
  logic [IDX_W-1:0] cp_slot = '0;
  logic [NAME_W-1:0] cp_name = '0;
  logic [SEQ_W-1:0] cp_lo = '0, cp_hi = '0;
  logic free_valid = 1'b0;
  logic [IDX_W-1:0] free_slot = '0;
  logic mp_valid = 1'b0;
  logic [SEQ_W-1:0] mp_seq = '0;
  logic rst_valid, busy;
  logic [IDX_W-1:0] rst_slot;
  logic [NAME_W-1:0] rst_name;

  always #2.5 clk = ~clk;  // 200 MHz

  l2_copy_recovery #(.ENTRIES(ENTRIES), .L1_REGS(64), .ROB_SIZE(32)) i_l2_copy_recovery (
    .clk(clk), .rst_n(rst_n),
    .cp_valid(cp_valid), .cp_slot(cp_slot), .cp_name(cp_name), .cp_lo(cp_lo), .cp_hi(cp_hi),
    .free_valid(free_valid), .free_slot(free_slot),
    .mp_valid(mp_valid), .mp_seq(mp_seq),
    .rst_valid(rst_valid), .rst_slot(rst_slot), .rst_name(rst_name), .busy(busy)
  );

  typedef struct { int slot; int name; string tag; } exp_t;
  exp_t sb_q[$];

  int n_run = 0, n_fail = 0, cyc = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;

  bit m_valid[ENTRIES];
  int m_name[ENTRIES], m_lo[ENTRIES], m_hi[ENTRIES];

  function automatic bit covers(int lo, int hi, int s);
    if (lo < hi) return (s >= lo) && (s < hi);
    if (lo > hi) return (s >= lo) || (s < hi);
    return 1'b0;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic do_copy(int slot, int name, int lo, int hi, bit also_free = 1'b0);
    @(posedge clk); #1;
    cp_valid = 1'b1; cp_slot = IDX_W'(slot); cp_name = NAME_W'(name);
    cp_lo = SEQ_W'(lo); cp_hi = SEQ_W'(hi);
    free_valid = also_free; free_slot = IDX_W'(slot);
    m_valid[slot] = 1'b1; m_name[slot] = name; m_lo[slot] = lo; m_hi[slot] = hi;
    @(posedge clk); #1;
    cp_valid = 1'b0; free_valid = 1'b0;
  endtask

  task automatic do_free(int slot);
    @(posedge clk); #1;
    free_valid = 1'b1; free_slot = IDX_W'(slot);
    m_valid[slot] = 1'b0;
    @(posedge clk); #1;
    free_valid = 1'b0;
  endtask

  task automatic do_mp(int s, string tag);
    @(posedge clk); #1;
    mp_valid = 1'b1; mp_seq = SEQ_W'(s);
    if (sb_q.size() == 0) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (m_valid[i] && covers(m_lo[i], m_hi[i], s)) begin
          exp_t e;
          e.slot = i; e.name = m_name[i]; e.tag = tag;
          sb_q.push_back(e);
          m_valid[i] = 1'b0;
        end
      end
    end
    @(posedge clk); #1;
    mp_valid = 1'b0;
  endtask

  task automatic settle(string tag);
    for (int k = 0; k < 40 && sb_q.size() != 0; k++) @(negedge clk);
    @(negedge clk); @(negedge clk);
    check(sb_q.size() == 0, tag, "requests still expected", 0, sb_q.size());
    check(busy == 1'b0 && rst_valid == 1'b0, tag, "idle after drain", int'(busy), 0);
  endtask

  // Monitor: compare each request against the scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      if (rst_valid) begin
        check(busy == 1'b1, "R4", "busy with request", int'(busy), 1);
        if (sb_q.size() == 0) begin
          check(1'b0, "R2", "unexpected request slot", int'(rst_slot), -1);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(int'(rst_slot) == e.slot, e.tag, "slot order", int'(rst_slot), e.slot);
          check(int'(rst_name) == e.name, e.tag, "name", int'(rst_name), e.name);
        end
      end else begin
        if (busy) check(1'b0, "R4", "busy without request", 1, 0);
      end
    end
  end

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
      finish_up();
    end
  end

  initial begin
    for (int i = 0; i < ENTRIES; i++) m_valid[i] = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(rst_valid == 1'b0, "R1", "rst_valid after reset", int'(rst_valid), 0);
    check(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    mon_on = 1'b1;
    do_mp(5, "R1");  // no valid records: no request
    settle("R1");

    // R2 R3: boundary lo inclusive, hi exclusive
    do_copy(0, 10, 2, 8);
    do_copy(1, 11, 5, 6);
    do_copy(2, 12, 9, 12);
    do_copy(3, 13, 0, 5);
    do_copy(4, 14, 6, 20);
    do_mp(5, "R2");
    settle("R2");
    do_mp(9, "R3");
    settle("R3");

    // R6: wrapped windows
    do_copy(5, 20, 30, 3);
    do_copy(6, 21, 29, 31);
    do_mp(31, "R6");
    settle("R6");
    do_copy(5, 22, 30, 3);
    do_mp(1, "R6");
    settle("R6");

    // R7: mispredict while draining is dropped
    for (int i = 0; i < 5; i++) do_copy(i, 30 + i, 10, 15);
    do_copy(7, 40, 20, 25);
    do_mp(12, "R7");
    do_mp(22, "R7");
    settle("R7");
    do_mp(22, "R7");
    settle("R7");

    // R8: restored records are gone
    do_mp(12, "R8");
    settle("R8");

    // R9: overwrite replaces name and window
    do_copy(3, 41, 1, 4);
    do_copy(3, 42, 7, 9);
    do_mp(2, "R9");
    settle("R9");
    do_mp(8, "R9");
    settle("R9");

    // R10: empty window
    do_copy(2, 43, 6, 6);
    do_mp(6, "R10");
    settle("R10");

    // R5: freed record silent
    do_copy(4, 44, 3, 10);
    do_free(4);
    do_mp(4, "R5");
    settle("R5");

    // R11: copy beats free on same slot
    do_copy(1, 45, 0, 2, 1'b1);
    do_mp(1, "R11");
    settle("R11");

    finish_up();
  end
endmodule